// File: doc/BRIEF.md
# Half-Duplex Back-Pressure Transmit Controller

This block lives in the transmit side of a half-duplex Ethernet MAC. When the receive side wants the link partner to stop sending, it raises a back-pressure request. The controller then fills the shared medium with preamble so that other stations see carrier. The block stops the preamble at set intervals so that neighbours are not held off indefinitely.

A collision during preamble still gets a minimum on-wire time. The block then goes silent, either for one inter-packet gap or for a truncated binary exponential backoff, depending on a mode bit. Such collisions are never counted.

When a frame is pending, the controller stops the preamble and waits one inter-packet gap. It then grants the frame path the wire. It owns retry timing for collisions on that frame, and these collisions are counted. Carrier sense is deliberately ignored throughout.

Top module: `bp_tx_ctrl`

## Requirements
- R1: One cycle after bp_req rises in the idle state, tx_en and pre_sel are both 1 (preamble on the wire). If bp_req is low during a preamble cycle with no collision pending, the next cycle is idle (tx_en=0).
- R2: A collision seen in preamble cycle k of a burst (k counted from 0) ends the burst after max(k+1, MIN_JAM) preamble cycles, with MIN_JAM defaulting to 96.
- R3: With no_backoff=1, a preamble collision is followed by exactly IPG_LEN (default 96) idle cycles and then a fresh preamble burst.
- R4: With no_backoff=0, a collision is followed by slots*SLOT_LEN idle cycles. Here slots = rnd_i & (2^e - 1). For a preamble collision, e is the number of preamble collisions since back pressure began, capped at EXP_CAP (default 10). A zero-slot backoff gives one idle cycle.
- R5: Collisions during preamble never pulse col_inc.
- R6: Uninterrupted preamble runs for exactly BURST_LEN cycles. The line is then idle for OFF_LEN cycles, and the pattern repeats.
- R7: A frame_req seen during a preamble cycle ends preamble after that cycle. IPG_LEN idle cycles follow. Then start_grant is 1 for one cycle, in the first frame cycle (tx_en=1, pre_sel=0).
- R8: A collision in a frame cycle gives a one-cycle col_inc pulse in the next cycle. The line is then idle for IPG_LEN cycles (no_backoff=1) or for a backoff with e = min(attempts, EXP_CAP) (no_backoff=0). The frame is then re-granted with start_grant.
- R9: On the TRY_LIMIT-th (default 16) collision of one frame, excess_col and col_inc pulse together and the frame is abandoned. If bp_req is high, preamble resumes in the next cycle.
- R10: frame_done seen in a frame cycle ends the frame. If bp_req is high, the next cycle starts a full preamble burst.
- R11: crs_i has no effect: preamble starts, gaps end and grants issue with carrier present.
- R12: During reset, tx_en, pre_sel, start_grant, col_inc and excess_col are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock, one bit time per cycle |
| rst_n | input | 1 | Asynchronous active-low reset |
| bp_req | input | 1 | Back-pressure request |
| col_i | input | 1 | Collision detected on the medium |
| crs_i | input | 1 | Carrier sense (ignored) |
| frame_req | input | 1 | A frame is waiting to be sent |
| frame_done | input | 1 | Frame path has finished the granted frame |
| no_backoff | input | 1 | 1: wait one gap after collisions; 0: random backoff |
| rnd_i | input | RND_W | Random source for backoff slot selection |
| tx_en | output | 1 | Transmitter drives the medium |
| pre_sel | output | 1 | Medium carries preamble (1) rather than frame data (0) |
| start_grant | output | 1 | One-cycle pulse: frame path may transmit |
| col_inc | output | 1 | One-cycle pulse: increment collision statistic |
| excess_col | output | 1 | One-cycle pulse: frame abandoned after too many collisions |

## Verification
The bench records each run of idle, preamble and frame on the wire and compares its length against a queue of expected runs. The probes include a collision in the very first preamble cycle, which a design that drops preamble at once would cut short of 96 bits, and a late collision, which a design adding a fixed 96 after the hit would over-extend. Backoff runs are checked with random values whose upper bits must be masked, and past the exponent cap, where an uncapped mask would double the wait. Frame retries are driven to the sixteenth collision so that an off-by-one attempt limit shows as an extra or missing grant, and carrier stays asserted in every scenario, so any deferral would stretch a gap.

// File: rtl/bp_tx_ctrl.sv
module bp_tx_ctrl #(
  parameter int IPG_LEN   = 96,
  parameter int MIN_JAM   = 96,
  parameter int SLOT_LEN  = 512,
  parameter int BURST_LEN = 1024,
  parameter int OFF_LEN   = 64,
  parameter int EXP_CAP   = 10,
  parameter int TRY_LIMIT = 16,
  parameter int RND_W     = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bp_req,
  input  logic             col_i,
  input  logic             crs_i,
  input  logic             frame_req,
  input  logic             frame_done,
  input  logic             no_backoff,
  input  logic [RND_W-1:0] rnd_i,
  output logic             tx_en,
  output logic             pre_sel,
  output logic             start_grant,
  output logic             col_inc,
  output logic             excess_col
);
  localparam int WAIT_MAX = ((1 << EXP_CAP) - 1) * SLOT_LEN;
  localparam int M1 = (WAIT_MAX > BURST_LEN) ? WAIT_MAX : BURST_LEN;
  localparam int M2 = (OFF_LEN > IPG_LEN) ? OFF_LEN : IPG_LEN;
  localparam int CNT_MAX = (M1 > M2) ? M1 : M2;
  localparam int CNT_W = $clog2(CNT_MAX + 1);
  localparam int PC_W = $clog2(EXP_CAP + 1);
  localparam int AT_W = $clog2(TRY_LIMIT);
  localparam int PW = CNT_W + RND_W;

  typedef enum logic [2:0] {S_IDLE, S_JAM, S_OFF, S_WAIT, S_GAP, S_FRAME} st_t;

  st_t              st;
  logic [CNT_W-1:0] cnt;
  logic             hit, retry;
  logic [PC_W-1:0]  pcol, pnext;
  logic [AT_W-1:0]  tries;
  logic [CNT_W-1:0] bo_p, bo_f;

  function automatic logic [CNT_W-1:0] backoff(input int k, input logic [RND_W-1:0] r);
    logic [RND_W-1:0] m;
    logic [PW-1:0] p;
    if (k >= RND_W) m = '1;
    else m = (RND_W'(1) << k) - RND_W'(1);
    p = PW'(r & m) * PW'(SLOT_LEN);
    return p[CNT_W-1:0];
  endfunction

  assign pnext = (pcol == PC_W'(EXP_CAP)) ? pcol : pcol + PC_W'(1);

  always_comb begin
    int kf;
    kf = int'(tries) + 1;
    if (kf > EXP_CAP) kf = EXP_CAP;
    bo_p = backoff(int'(pnext), rnd_i);
    bo_f = backoff(kf, rnd_i);
  end

  assign tx_en   = (st == S_JAM) || (st == S_FRAME);
  assign pre_sel = (st == S_JAM);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE;
      cnt <= '0;
      hit <= 1'b0;
      retry <= 1'b0;
      pcol <= '0;
      tries <= '0;
      start_grant <= 1'b0;
      col_inc <= 1'b0;
      excess_col <= 1'b0;
    end else begin
      start_grant <= 1'b0;
      col_inc <= 1'b0;
      excess_col <= 1'b0;
      case (st)
        S_IDLE: begin
          pcol <= '0;
          if (bp_req) begin
            st <= S_JAM;
            cnt <= '0;
            hit <= 1'b0;
          end
        end
        S_JAM: begin
          if (hit || col_i) begin
            if (cnt >= CNT_W'(MIN_JAM - 1)) begin
              st <= S_WAIT;
              retry <= 1'b0;
              hit <= 1'b0;
              pcol <= pnext;
              cnt <= no_backoff ? CNT_W'(IPG_LEN) : bo_p;
            end else begin
              hit <= 1'b1;
              cnt <= cnt + CNT_W'(1);
            end
          end else if (!bp_req) begin
            st <= S_IDLE;
          end else if (frame_req) begin
            st <= S_GAP;
            cnt <= CNT_W'(IPG_LEN);
          end else if (cnt == CNT_W'(BURST_LEN - 1)) begin
            st <= S_OFF;
            cnt <= CNT_W'(OFF_LEN);
          end else begin
            cnt <= cnt + CNT_W'(1);
          end
        end
        S_OFF: begin
          if (!bp_req) st <= S_IDLE;
          else if (cnt <= CNT_W'(1)) begin
            st <= S_JAM;
            cnt <= '0;
          end else cnt <= cnt - CNT_W'(1);
        end
        S_WAIT: begin
          if (cnt <= CNT_W'(1)) begin
            if (retry) begin
              st <= S_FRAME;
              start_grant <= 1'b1;
            end else if (!bp_req) begin
              st <= S_IDLE;
            end else if (frame_req) begin
              st <= S_GAP;
              cnt <= CNT_W'(IPG_LEN);
            end else begin
              st <= S_JAM;
              cnt <= '0;
            end
          end else cnt <= cnt - CNT_W'(1);
        end
        S_GAP: begin
          if (cnt <= CNT_W'(1)) begin
            st <= S_FRAME;
            start_grant <= 1'b1;
          end else cnt <= cnt - CNT_W'(1);
        end
        S_FRAME: begin
          if (col_i) begin
            col_inc <= 1'b1;
            if (tries == AT_W'(TRY_LIMIT - 1)) begin
              excess_col <= 1'b1;
              tries <= '0;
              retry <= 1'b0;
              st <= bp_req ? S_JAM : S_IDLE;
              cnt <= '0;
              hit <= 1'b0;
            end else begin
              tries <= tries + AT_W'(1);
              retry <= 1'b1;
              st <= S_WAIT;
              cnt <= no_backoff ? CNT_W'(IPG_LEN) : bo_f;
            end
          end else if (frame_done) begin
            tries <= '0;
            retry <= 1'b0;
            st <= bp_req ? S_JAM : S_IDLE;
            cnt <= '0;
            hit <= 1'b0;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  p_min_jam_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (pre_sel && col_i && cnt < CNT_W'(MIN_JAM - 1)) |=> pre_sel);

  p_preamble_uncounted_r5: assert property (@(posedge clk) disable iff (!rst_n)
    pre_sel |=> !col_inc);

  p_grant_after_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
    start_grant |-> (!$past(tx_en) && tx_en && !pre_sel));

  p_frame_col_counted_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_en && !pre_sel && col_i) |=> col_inc);

  p_excess_counted_r9: assert property (@(posedge clk) disable iff (!rst_n)
    excess_col |-> (col_inc && !start_grant));

  p_no_defer_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_IDLE && bp_req && crs_i) |=> pre_sel);
endmodule

// File: tb/bp_tx_ctrl_test.sv
module bp_tx_ctrl_test;
  localparam int BURST = 300;
  localparam int OFFL  = 40;
  localparam int SLOT  = 4;
  localparam int IPG   = 96;
  localparam logic [1:0] M_IDLE = 2'b00, M_PRE = 2'b11, M_FRM = 2'b10;

  logic clk = 0, rst_n = 0;
  logic bp_req = 0, col_i = 0, crs_i = 0, frame_req = 0, frame_done = 0, no_backoff = 0;
  logic [15:0] rnd_i = '0;
  logic tx_en, pre_sel, start_grant, col_inc, excess_col;

  always #5 clk = ~clk;

  bp_tx_ctrl #(.BURST_LEN(BURST), .OFF_LEN(OFFL), .SLOT_LEN(SLOT)) uut (
    .clk(clk), .rst_n(rst_n), .bp_req(bp_req), .col_i(col_i), .crs_i(crs_i),
    .frame_req(frame_req), .frame_done(frame_done), .no_backoff(no_backoff),
    .rnd_i(rnd_i), .tx_en(tx_en), .pre_sel(pre_sel), .start_grant(start_grant),
    .col_inc(col_inc), .excess_col(excess_col));

  typedef struct {logic [1:0] mode; int len; string tag;} item_t;
  item_t q[$];
  int checks = 0, errors = 0;
  int n_grant = 0, n_colinc = 0, n_excess = 0;
  logic [1:0] run_mode = M_IDLE;
  int run_len = 0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic push(input logic [1:0] m, input int len, input string tag);
    item_t it;
    it.mode = m; it.len = len; it.tag = tag;
    q.push_back(it);
  endtask

  always @(negedge clk) begin
    if (!rst_n) begin
      run_len = 0;
      run_mode = M_IDLE;
    end else begin
      if (run_len > 0 && {tx_en, pre_sel} != run_mode) begin
        if (q.size() > 0) begin
          item_t it;
          it = q.pop_front();
          chk(it.mode == run_mode, {it.tag, " mode"}, run_mode, it.mode);
          if (it.len != 0) chk(it.len == run_len, {it.tag, " length"}, run_len, it.len);
        end
        run_len = 0;
      end
      run_mode = {tx_en, pre_sel};
      run_len++;
      if (start_grant) n_grant++;
      if (col_inc) n_colinc++;
      if (excess_col) n_excess++;
    end
  end

  task automatic do_reset();
    rst_n = 0; bp_req = 0; col_i = 0; frame_req = 0; frame_done = 0;
    repeat (3) @(negedge clk);
    q.delete();
    n_grant = 0; n_colinc = 0; n_excess = 0;
    rst_n = 1;
    push(M_IDLE, 0, "lead-in");
  endtask

  task automatic drain();
    while (q.size() != 0) @(negedge clk);
  endtask

  task automatic wait_pre_start();
    while (tx_en && pre_sel) @(negedge clk);
    while (!(tx_en && pre_sel)) @(negedge clk);
  endtask

  task automatic wait_grant();
    while (!start_grant) @(negedge clk);
  endtask

  task automatic pulse_col();
    col_i = 1; @(negedge clk); col_i = 0;
  endtask

  task automatic pulse_done();
    frame_done = 1; @(negedge clk); frame_done = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    crs_i = 1;
    // R12 reset values
    rst_n = 0;
    repeat (2) @(negedge clk);
    chk({tx_en, pre_sel, start_grant, col_inc, excess_col} == 5'b0, "R12 reset outputs",
        {tx_en, pre_sel, start_grant, col_inc, excess_col}, 0);

    // R1/R6/R11: burst and carrier drop cadence with carrier present
    do_reset();
    no_backoff = 1;
    push(M_PRE, BURST, "R6 burst"); push(M_IDLE, OFFL, "R6 off");
    push(M_PRE, BURST, "R6 burst2");
    @(negedge clk); bp_req = 1;
    @(negedge clk);
    chk(tx_en && pre_sel, "R1 R11 preamble starts", {tx_en, pre_sel}, 3);
    drain();

    // R1: drop request mid-burst
    do_reset();
    push(M_PRE, 6, "R1 stop");
    @(negedge clk); bp_req = 1;
    wait_pre_start(); repeat (5) @(negedge clk); bp_req = 0;
    repeat (2) @(negedge clk);
    chk(!tx_en, "R1 idle after release", tx_en, 0);
    drain();

    // R2/R3/R5: early preamble collision, no backoff
    do_reset();
    no_backoff = 1;
    push(M_PRE, 96, "R2 early"); push(M_IDLE, IPG, "R3 gap");
    push(M_PRE, BURST, "R3 resume");
    @(negedge clk); bp_req = 1;
    wait_pre_start(); pulse_col();
    drain();
    chk(n_colinc == 0, "R5 no count", n_colinc, 0);

    // R2/R4: late collision then masked backoff
    do_reset();
    no_backoff = 0; rnd_i = 16'd3;
    push(M_PRE, 151, "R2 late"); push(M_IDLE, 1 * SLOT, "R4 e1");
    push(M_PRE, 96, "R2 second"); push(M_IDLE, 3 * SLOT, "R4 e2");
    push(M_PRE, BURST, "R4 resume");
    @(negedge clk); bp_req = 1;
    wait_pre_start(); repeat (150) @(negedge clk); pulse_col();
    wait_pre_start(); pulse_col();
    drain();
    chk(n_colinc == 0, "R5 no count backoff", n_colinc, 0);

    // R4: exponent capped
    do_reset();
    no_backoff = 0; rnd_i = 16'hFFFF;
    for (int j = 1; j <= 11; j++) begin
      int e;
      e = (j > 10) ? 10 : j;
      push(M_PRE, 96, "R2 cap burst");
      push(M_IDLE, ((1 << e) - 1) * SLOT, "R4 cap wait");
    end
    push(M_PRE, BURST, "R4 cap resume");
    @(negedge clk); bp_req = 1;
    for (int j = 1; j <= 11; j++) begin
      wait_pre_start(); pulse_col();
    end
    drain();

    // R7/R10: frame handover
    do_reset();
    no_backoff = 1;
    push(M_PRE, 11, "R7 cut"); push(M_IDLE, IPG, "R7 gap");
    push(M_FRM, 51, "R10 frame"); push(M_PRE, BURST, "R10 resume");
    @(negedge clk); bp_req = 1;
    wait_pre_start(); repeat (10) @(negedge clk); frame_req = 1;
    wait_grant(); frame_req = 0;
    repeat (50) @(negedge clk); pulse_done();
    drain();
    chk(n_grant == 1, "R7 one grant", n_grant, 1);

    // R8: frame collision with gap retry
    do_reset();
    no_backoff = 1;
    push(M_PRE, 11, "R7 cut"); push(M_IDLE, IPG, "R7 gap");
    push(M_FRM, 21, "R8 hit"); push(M_IDLE, IPG, "R8 gap");
    push(M_FRM, 31, "R8 retry"); push(M_PRE, BURST, "R10 resume");
    @(negedge clk); bp_req = 1;
    wait_pre_start(); repeat (10) @(negedge clk); frame_req = 1;
    wait_grant(); frame_req = 0;
    repeat (20) @(negedge clk); pulse_col();
    wait_grant(); repeat (30) @(negedge clk); pulse_done();
    drain();
    chk(n_colinc == 1, "R8 counted", n_colinc, 1);
    chk(n_grant == 2, "R8 regrant", n_grant, 2);

    // R8/R4: frame collision with zero-slot backoff
    do_reset();
    no_backoff = 0; rnd_i = 16'd2;
    push(M_PRE, 11, "R7 cut"); push(M_IDLE, IPG, "R7 gap");
    push(M_FRM, 21, "R8 hit"); push(M_IDLE, 1, "R8 R4 zero slot");
    push(M_FRM, 31, "R8 retry"); push(M_PRE, BURST, "R10 resume");
    @(negedge clk); bp_req = 1;
    wait_pre_start(); repeat (10) @(negedge clk); frame_req = 1;
    wait_grant(); frame_req = 0;
    repeat (20) @(negedge clk); pulse_col();
    wait_grant(); repeat (30) @(negedge clk); pulse_done();
    drain();
    chk(n_colinc == 1, "R8 counted backoff", n_colinc, 1);

    // R9: attempt limit
    do_reset();
    no_backoff = 1;
    push(M_PRE, 11, "R7 cut"); push(M_IDLE, IPG, "R7 gap");
    for (int j = 0; j < 15; j++) begin
      push(M_FRM, 1, "R9 try"); push(M_IDLE, IPG, "R9 gap");
    end
    push(M_FRM, 1, "R9 last"); push(M_PRE, BURST, "R9 resume");
    @(negedge clk); bp_req = 1;
    wait_pre_start(); repeat (10) @(negedge clk); frame_req = 1;
    for (int j = 0; j < 16; j++) begin
      wait_grant();
      frame_req = 0;
      pulse_col();
    end
    drain();
    chk(n_colinc == 16, "R9 all counted", n_colinc, 16);
    chk(n_excess == 1, "R9 excess flag", n_excess, 1);
    chk(n_grant == 16, "R9 grants", n_grant, 16);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule